// File: doc/BRIEF.md
# Armed Configuration-Byte Read-Back Unit

This unit sits in the read path for program-memory load instructions in a small processor core. Normally a load returns the flash data word that the memory delivers for the Z address. Software can open a short read window by writing the control register with two flags set together: the select-configuration flag and the store-enable flag. While the window is open, the next load does not return flash data. It returns one of four configuration bytes, chosen by the low Z address values 0 to 3. These are the fuse low byte, the lock byte, the extended fuse byte and the fuse high byte.

The nonvolatile configuration bits arrive as "programmed" flags, where 1 means programmed. The unit inverts them, so a programmed bit reads as 0 and an unprogrammed bit reads as 1. Bit positions that do not exist read as 1. The window closes by itself after three clock cycles, or after the first load that uses it, whichever comes first.

A two-state machine tracks the window. In IDLE, no window is open. In ARMED, a window is open and a down-counter holds the cycles it has left. The machine has five named transitions:
- ARM: any state to ARMED, taken on a write that sets both flags.
- DISARM: any state to IDLE, taken on a write that does not set both flags.
- CONSUME: ARMED to IDLE, taken on a load.
- EXPIRE: ARMED to IDLE, taken when the counter is 0.
- COUNT: ARMED to ARMED, which decrements the counter.

A control write takes priority over CONSUME and EXPIRE in the same cycle.

Top module: `cfg_readback_unit`

## Requirements
- R1: A control write with bit 3 (select-configuration) and bit 0 (store-enable) both 1 opens a window. A load in any of the three cycles after that write returns a configuration byte.
- R2: A load at Z = 0x0000 inside the window returns the bitwise inverse of `fuse_lo_prog`.
- R3: A load at Z = 0x0003 inside the window returns the bitwise inverse of `fuse_hi_prog`.
- R4: A load at Z = 0x0002 inside the window returns 1111 in bits 7 to 4 and the inverse of `fuse_ext_prog` in bits 3 to 0.
- R5: A load at Z = 0x0001 inside the window returns 1 in every bit above the lock field and the inverse of `lock_prog` in the low bits.
- R6: A load in the fourth cycle after the arming write, or later, returns `flash_rdata`.
- R7: A load inside the window closes it. A second load in the next cycle returns `flash_rdata`.
- R8: A control write without both flags set does not open a window. If a window is open, such a write closes it.
- R9: A load inside the window at a Z address of 0x0004 or above returns `flash_rdata`.
- R10: A load in the same cycle as the arming write returns `flash_rdata`. A load in the cycle after that write returns a configuration byte.
- R11: A synchronous active-high `rst` closes the window and clears `ld_rdata` to 0x00.
- R12: `ld_rdata` takes its new value on the clock edge that samples `ld_req`, and keeps its value in cycles without a load.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ctl_wr | input | 1 | Control register write strobe |
| ctl_wdata | input | 8 | Control write data: bit 3 is select-configuration, bit 0 is store-enable |
| ld_req | input | 1 | Program-memory load instruction strobe |
| ld_zaddr | input | 16 | Z address of the load |
| flash_rdata | input | 8 | Flash data for `ld_zaddr`, valid in the cycle of `ld_req` |
| fuse_lo_prog | input | 8 | Programmed flags of the fuse low byte (1 = programmed) |
| fuse_hi_prog | input | 8 | Programmed flags of the fuse high byte |
| fuse_ext_prog | input | 4 | Programmed flags of the extended fuse byte |
| lock_prog | input | 6 | Programmed flags of the lock bits |
| ld_rdata | output | 8 | Byte for the destination register |

## Verification
Two events can fall in the same cycle: a load request and a change of the window. The window can be opened by the arming write, or closed by expiry in the last window cycle. The bench places a load in the same cycle as the arming write, where flash data is expected. It places a load in the third cycle after the write, where the configuration byte is still expected. It also issues back-to-back loads, where only the first one sees configuration data. Each of these outcomes is judged against bytes that the bench computes from its own fuse and flash stimulus.

// File: rtl/cfgrb_pkg.sv
package cfgrb_pkg;

    typedef enum logic [0:0] {
        ST_IDLE  = 1'b0,
        ST_ARMED = 1'b1
    } arm_state_t;

    typedef enum logic [2:0] {
        SRC_FLASH,
        SRC_FUSE_LO,
        SRC_LOCK,
        SRC_FUSE_EXT,
        SRC_FUSE_HI
    } byte_src_t;

    localparam logic [15:0] Z_FUSE_LO  = 16'h0000;
    localparam logic [15:0] Z_LOCK     = 16'h0001;
    localparam logic [15:0] Z_FUSE_EXT = 16'h0002;
    localparam logic [15:0] Z_FUSE_HI  = 16'h0003;

endpackage

// File: rtl/cfgrb_arm_fsm.sv
module cfgrb_arm_fsm
    import cfgrb_pkg::*;
#(
    parameter int unsigned WIN     = 3,
    parameter int unsigned CTRL_W  = 8,
    parameter int unsigned SEL_BIT = 3,
    parameter int unsigned EN_BIT  = 0
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ctl_wr,
    input  logic [CTRL_W-1:0] ctl_wdata,
    input  logic              ld_req,
    output logic              window_open
);

    localparam int unsigned CNT_W = $clog2(WIN + 1);
    localparam logic [CNT_W-1:0] WIN_LAST = CNT_W'(WIN - 1);

    arm_state_t       st_q, st_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;
    logic             arm_req;

    assign arm_req = ctl_wdata[SEL_BIT] & ctl_wdata[EN_BIT];

    // Next-state logic: ARM, DISARM, CONSUME, EXPIRE, COUNT
    always_comb begin
        st_d  = st_q;
        cnt_d = cnt_q;
        if (ctl_wr) begin
            if (arm_req) begin
                st_d  = ST_ARMED;
                cnt_d = WIN_LAST;
            end else begin
                st_d  = ST_IDLE;
                cnt_d = '0;
            end
        end else begin
            unique case (st_q)
                ST_IDLE: begin
                    st_d  = ST_IDLE;
                end
                ST_ARMED: begin
                    if (ld_req || cnt_q == '0) begin
                        st_d  = ST_IDLE;
                        cnt_d = '0;
                    end else begin
                        cnt_d = cnt_q - 1'b1;
                    end
                end
                default: begin
                    st_d  = ST_IDLE;
                    cnt_d = '0;
                end
            endcase
        end
    end

    // State register
    always_ff @(posedge clk) begin
        if (rst) begin
            st_q  <= ST_IDLE;
            cnt_q <= '0;
        end else begin
            st_q  <= st_d;
            cnt_q <= cnt_d;
        end
    end

    // Outputs
    always_comb begin
        unique case (st_q)
            ST_ARMED: window_open = 1'b1;
            default:  window_open = 1'b0;
        endcase
    end

    a_r1_arm_opens: assert property (@(posedge clk) disable iff (rst)
        (ctl_wr && arm_req) |=> (st_q == ST_ARMED && cnt_q == WIN_LAST));

    a_r8_single_flag_closed: assert property (@(posedge clk) disable iff (rst)
        (ctl_wr && !arm_req) |=> (st_q == ST_IDLE));

    a_r7_load_consumes: assert property (@(posedge clk) disable iff (rst)
        (st_q == ST_ARMED && ld_req && !ctl_wr) |=> (st_q == ST_IDLE));

    a_r6_window_expires: assert property (@(posedge clk) disable iff (rst)
        (st_q == ST_ARMED && cnt_q == '0 && !ctl_wr) |=> (st_q == ST_IDLE));

    a_r11_reset_idle: assert property (@(posedge clk)
        rst |=> (st_q == ST_IDLE && cnt_q == '0));

endmodule

// File: rtl/cfgrb_src_sel.sv
module cfgrb_src_sel
    import cfgrb_pkg::*;
#(
    parameter int unsigned ADDR_W = 16,
    parameter int unsigned DATA_W = 8,
    parameter int unsigned EXT_W  = 4,
    parameter int unsigned LOCK_W = 6
) (
    input  logic              window_open,
    input  logic [ADDR_W-1:0] zaddr,
    input  logic [DATA_W-1:0] flash_rdata,
    input  logic [DATA_W-1:0] fuse_lo_prog,
    input  logic [DATA_W-1:0] fuse_hi_prog,
    input  logic [EXT_W-1:0]  fuse_ext_prog,
    input  logic [LOCK_W-1:0] lock_prog,
    output logic [DATA_W-1:0] rdata
);

    localparam int unsigned EXT_PAD  = DATA_W - EXT_W;
    localparam int unsigned LOCK_PAD = DATA_W - LOCK_W;

    logic [DATA_W-1:0] ext_byte;
    logic [DATA_W-1:0] lock_byte;
    byte_src_t         src;

    // Programmed bits read 0, absent bit positions read 1
    generate
        if (EXT_PAD > 0) begin : g_ext_pad
            assign ext_byte = {{EXT_PAD{1'b1}}, ~fuse_ext_prog};
        end else begin : g_ext_full
            assign ext_byte = ~fuse_ext_prog[DATA_W-1:0];
        end
        if (LOCK_PAD > 0) begin : g_lock_pad
            assign lock_byte = {{LOCK_PAD{1'b1}}, ~lock_prog};
        end else begin : g_lock_full
            assign lock_byte = ~lock_prog[DATA_W-1:0];
        end
    endgenerate

    always_comb begin
        src = SRC_FLASH;
        if (window_open) begin
            unique case (zaddr)
                ADDR_W'(Z_FUSE_LO):  src = SRC_FUSE_LO;
                ADDR_W'(Z_LOCK):     src = SRC_LOCK;
                ADDR_W'(Z_FUSE_EXT): src = SRC_FUSE_EXT;
                ADDR_W'(Z_FUSE_HI):  src = SRC_FUSE_HI;
                default:             src = SRC_FLASH;
            endcase
        end
    end

    always_comb begin
        unique case (src)
            SRC_FUSE_LO:  rdata = ~fuse_lo_prog;
            SRC_LOCK:     rdata = lock_byte;
            SRC_FUSE_EXT: rdata = ext_byte;
            SRC_FUSE_HI:  rdata = ~fuse_hi_prog;
            default:      rdata = flash_rdata;
        endcase
    end

endmodule

// File: rtl/cfg_readback_unit.sv
module cfg_readback_unit
    import cfgrb_pkg::*;
#(
    parameter int unsigned WIN     = 3,
    parameter int unsigned ADDR_W  = 16,
    parameter int unsigned DATA_W  = 8,
    parameter int unsigned EXT_W   = 4,
    parameter int unsigned LOCK_W  = 6,
    parameter int unsigned SEL_BIT = 3,
    parameter int unsigned EN_BIT  = 0
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ctl_wr,
    input  logic [7:0]        ctl_wdata,
    input  logic              ld_req,
    input  logic [ADDR_W-1:0] ld_zaddr,
    input  logic [DATA_W-1:0] flash_rdata,
    input  logic [DATA_W-1:0] fuse_lo_prog,
    input  logic [DATA_W-1:0] fuse_hi_prog,
    input  logic [EXT_W-1:0]  fuse_ext_prog,
    input  logic [LOCK_W-1:0] lock_prog,
    output logic [DATA_W-1:0] ld_rdata
);

    logic              window_open;
    logic [DATA_W-1:0] sel_byte;

    cfgrb_arm_fsm #(
        .WIN     (WIN),
        .CTRL_W  (8),
        .SEL_BIT (SEL_BIT),
        .EN_BIT  (EN_BIT)
    ) u_fsm (
        .clk         (clk),
        .rst         (rst),
        .ctl_wr      (ctl_wr),
        .ctl_wdata   (ctl_wdata),
        .ld_req      (ld_req),
        .window_open (window_open)
    );

    cfgrb_src_sel #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W),
        .EXT_W  (EXT_W),
        .LOCK_W (LOCK_W)
    ) u_sel (
        .window_open   (window_open),
        .zaddr         (ld_zaddr),
        .flash_rdata   (flash_rdata),
        .fuse_lo_prog  (fuse_lo_prog),
        .fuse_hi_prog  (fuse_hi_prog),
        .fuse_ext_prog (fuse_ext_prog),
        .lock_prog     (lock_prog),
        .rdata         (sel_byte)
    );

    // Destination-register byte, captured on each load
    always_ff @(posedge clk) begin
        if (rst) begin
            ld_rdata <= '0;
        end else if (ld_req) begin
            ld_rdata <= sel_byte;
        end
    end

    a_r12_hold_without_load: assert property (@(posedge clk) disable iff (rst)
        !ld_req |=> $stable(ld_rdata));

    a_r9_closed_returns_flash: assert property (@(posedge clk) disable iff (rst)
        (ld_req && !window_open) |=> (ld_rdata == $past(flash_rdata)));

    a_r9_high_z_returns_flash: assert property (@(posedge clk) disable iff (rst)
        (ld_req && ld_zaddr > ADDR_W'(3)) |=> (ld_rdata == $past(flash_rdata)));

    a_r4_ext_upper_ones: assert property (@(posedge clk) disable iff (rst)
        (ld_req && window_open && ld_zaddr == ADDR_W'(Z_FUSE_EXT))
        |=> (ld_rdata[DATA_W-1:EXT_W] == '1));

    a_r2_fuse_lo_inverted: assert property (@(posedge clk) disable iff (rst)
        (ld_req && window_open && ld_zaddr == ADDR_W'(Z_FUSE_LO))
        |=> (ld_rdata == ~$past(fuse_lo_prog)));

    a_r11_reset_clears: assert property (@(posedge clk)
        rst |=> (ld_rdata == '0));

endmodule

// File: tb/cfg_readback_unit_test.sv
module cfg_readback_unit_test;

    localparam int CLK_PERIOD = 10;
    localparam int NVEC = 12;

    // Vector fields: ctl data [30:23], gap [22:19], z [18:3], source [2:0]
    // Source: 0 flash, 1 fuse low, 2 fuse high, 3 extended, 4 lock
    localparam logic [30:0] VEC [NVEC] = '{
        {8'h09, 4'd0, 16'h0000, 3'd1},
        {8'h09, 4'd1, 16'h0003, 3'd2},
        {8'h09, 4'd2, 16'h0002, 3'd3},
        {8'h09, 4'd0, 16'h0001, 3'd4},
        {8'h09, 4'd3, 16'h0000, 3'd0},
        {8'h08, 4'd0, 16'h0000, 3'd0},
        {8'h01, 4'd0, 16'h0003, 3'd0},
        {8'h09, 4'd0, 16'h0004, 3'd0},
        {8'h09, 4'd1, 16'h8000, 3'd0},
        {8'h09, 4'd2, 16'h0001, 3'd4},
        {8'h00, 4'd0, 16'h0002, 3'd0},
        {8'h09, 4'd5, 16'h0001, 3'd0}
    };

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        ctl_wr = 1'b0;
    logic [7:0]  ctl_wdata = '0;
    logic        ld_req = 1'b0;
    logic [15:0] ld_zaddr = '0;
    logic [7:0]  flash_rdata;
    logic [7:0]  fuse_lo_prog = 8'hA5;
    logic [7:0]  fuse_hi_prog = 8'h3C;
    logic [3:0]  fuse_ext_prog = 4'h6;
    logic [5:0]  lock_prog = 6'h2D;
    logic [7:0]  ld_rdata;

    int checks = 0;
    int fails = 0;
    bit done = 1'b0;

    assign flash_rdata = ld_zaddr[7:0] ^ ld_zaddr[15:8] ^ 8'hC3;

    always #(CLK_PERIOD / 2) clk = ~clk;

    cfg_readback_unit uut (
        .clk           (clk),
        .rst           (rst),
        .ctl_wr        (ctl_wr),
        .ctl_wdata     (ctl_wdata),
        .ld_req        (ld_req),
        .ld_zaddr      (ld_zaddr),
        .flash_rdata   (flash_rdata),
        .fuse_lo_prog  (fuse_lo_prog),
        .fuse_hi_prog  (fuse_hi_prog),
        .fuse_ext_prog (fuse_ext_prog),
        .lock_prog     (lock_prog),
        .ld_rdata      (ld_rdata)
    );

    function automatic logic [7:0] flash_of(input logic [15:0] z);
        return z[7:0] ^ z[15:8] ^ 8'hC3;
    endfunction

    function automatic logic [7:0] expect_of(input logic [2:0] s, input logic [15:0] z);
        case (s)
            3'd1:    return ~fuse_lo_prog;
            3'd2:    return ~fuse_hi_prog;
            3'd3:    return {4'hF, ~fuse_ext_prog};
            3'd4:    return {2'b11, ~lock_prog};
            default: return flash_of(z);
        endcase
    endfunction

    task automatic check(input string req, input logic [7:0] got, input logic [7:0] exp);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s: ld_rdata=%02h expected=%02h", req, got, exp);
        end
    endtask

    task automatic ctl_write(input logic [7:0] d);
        @(negedge clk);
        ctl_wr = 1'b1;
        ctl_wdata = d;
        @(negedge clk);
        ctl_wr = 1'b0;
    endtask

    task automatic do_load(input logic [15:0] z);
        ld_req = 1'b1;
        ld_zaddr = z;
        @(negedge clk);
        ld_req = 1'b0;
    endtask

    task automatic settle();
        repeat (5) @(negedge clk);
    endtask

    string tags [NVEC] = '{"R2", "R3", "R4 R1", "R5", "R6", "R8", "R8",
                          "R9", "R9", "R5 R1", "R8", "R6"};

    initial begin
        repeat (3) @(negedge clk);
        check("R11 reset value", ld_rdata, 8'h00);
        rst = 1'b0;
        @(negedge clk);

        // Table walk: write, gap cycles, one load, sample after its edge
        for (int i = 0; i < NVEC; i++) begin
            logic [7:0]  d;
            logic [3:0]  gap;
            logic [15:0] z;
            logic [2:0]  s;
            {d, gap, z, s} = VEC[i];
            ctl_write(d);
            repeat (gap) @(negedge clk);
            do_load(z);
            check(tags[i], ld_rdata, expect_of(s, z));
            settle();
        end

        // R7: back-to-back loads, only the first sees configuration data
        ctl_write(8'h09);
        do_load(16'h0003);
        check("R7 first load", ld_rdata, ~fuse_hi_prog);
        do_load(16'h0003);
        check("R7 second load", ld_rdata, flash_of(16'h0003));
        settle();

        // R10: load in the same cycle as the arming write, then one after
        @(negedge clk);
        ctl_wr = 1'b1;
        ctl_wdata = 8'h09;
        ld_req = 1'b1;
        ld_zaddr = 16'h0000;
        @(negedge clk);
        ctl_wr = 1'b0;
        ld_req = 1'b0;
        check("R10 same-cycle load", ld_rdata, flash_of(16'h0000));
        do_load(16'h0000);
        check("R10 next-cycle load", ld_rdata, ~fuse_lo_prog);
        settle();

        // R8: plain write during an open window closes it
        ctl_write(8'h09);
        ctl_write(8'h01);
        do_load(16'h0002);
        check("R8 window closed by write", ld_rdata, flash_of(16'h0002));
        settle();

        // R12: output holds through idle cycles and a non-load write
        ctl_write(8'h09);
        do_load(16'h0001);
        repeat (3) @(negedge clk);
        ctl_write(8'h00);
        check("R12 hold", ld_rdata, {2'b11, ~lock_prog});
        settle();

        // R2/R3 with changed fuse values, programmed bits read 0
        fuse_lo_prog = 8'hFF;
        fuse_hi_prog = 8'h00;
        ctl_write(8'h09);
        do_load(16'h0000);
        check("R2 all programmed", ld_rdata, 8'h00);
        ctl_write(8'h09);
        do_load(16'h0003);
        check("R3 all unprogrammed", ld_rdata, 8'hFF);
        settle();

        // R11: reset inside an open window closes it and clears output
        ctl_write(8'h09);
        rst = 1'b1;
        @(negedge clk);
        check("R11 output cleared", ld_rdata, 8'h00);
        rst = 1'b0;
        do_load(16'h0000);
        check("R11 window closed", ld_rdata, flash_of(16'h0000));

        if (!done) begin
            done = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            fails++;
            $display("FAIL watchdog: ld_rdata=%02h expected=completion", ld_rdata);
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

endmodule